// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Mirrored Masks

This block gathers interrupt requests from twelve sources and hands them to a processor one at a time. Source 0 is the non-maskable pin. Sources 1 to 11 are maskable: five external pins, three timers, two DMA channels and a serial port. Each cycle the block picks the most urgent eligible request. It then drives a valid flag, the winning source index and a vector. The vector is a fixed base plus the index.

Each maskable source has a control register that holds a 3-bit priority level and a mask bit. The same mask bits can also be reached together through one global mask register. Both views read and write a single set of flops, so a mask change takes effect in full at one clock edge. The processor acknowledges the presented request, which marks that source in service. It later issues an end-of-interrupt naming a source, which clears that mark. A nesting enable bit decides what happens while a source is in service. With nesting on, a request of strictly more urgent level may preempt it. With nesting off, no maskable request is presented.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every maskable source is masked and at priority level 7. Nesting is off, no source is in service, and no maskable request is presented.
- R2: Address 0 is the global mask register: bit i is the mask of source i for i = 1..11, and bit 0 reads 0. Address 16+i is the control register of source i: bits [2:0] hold the level and bit 3 holds the mask. A write through either view changes the bit that the other view reads back.
- R3: A masked maskable source is never presented. A new mask value governs the output from the first cycle after the write edge.
- R4: Among eligible maskable sources, the lowest level value wins, and a tie goes to the lower index. A presented source is always currently requesting. The vector equals 32 plus the presented index.
- R5: Source 0 ignores every mask. It is presented whenever it requests and is not in service. While source 0 is in service, no maskable source is presented.
- R6: An acknowledge while a request is presented marks the presented source in service. An end-of-interrupt clears the mark of the source it names. If both hit the same source in one cycle, the mark ends up set.
- R7: With nesting off, no maskable source is presented while any maskable source is in service.
- R8: With nesting on, a maskable source is presented only if its level is strictly lower than the lowest level among the in-service maskable sources. A source that is already in service is never presented.
- R9: Bit 0 of address 1 is the nesting enable, and it reads back as written.
- R10: Addresses other than 0, 1 and 17..27 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 12 | Level request per source, bit 0 non-maskable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Register read data (combinational) |
| irq_ack | input | 1 | Acknowledge of the presented request |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 4 | Source index closed by end-of-interrupt |
| irq_valid | output | 1 | A request is presented |
| irq_id | output | 4 | Presented source index |
| irq_vec | output | 8 | Presented vector |

## Verification
An acknowledge and an end-of-interrupt can land in the same cycle. The bench provokes this twice. In the first case an end-of-interrupt closes an older in-service source while a newer one is acknowledged. In the second, both strobes name the same source. The outcome is judged only at the ports: after each collision, requests are applied whose presentation depends on exactly which in-service marks survived. The result is compared with a model that clears on end-of-interrupt first and then sets on acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_DEF      = 12;
  localparam int LVL_W_DEF    = 3;
  localparam int ADDR_W_DEF   = 5;
  localparam int CTL_BASE_DEF = 16;

  // True when (la, ia) is more urgent than (lb, ib): lower level, then lower index.
  function automatic bit outranks(input int la, input int ia, input int lb, input int ib);
    return (la < lb) || ((la == lb) && (ia < ib));
  endfunction

  function automatic int vector_of(input int base, input int idx);
    return base + idx;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int N        = irq_pkg::SRC_DEF,
  parameter int PW       = irq_pkg::LVL_W_DEF,
  parameter int AW       = irq_pkg::ADDR_W_DEF,
  parameter int CTL_BASE = irq_pkg::CTL_BASE_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [N-1:0]         wdata,
  output logic [N-1:0]         rdata,
  output logic [N-1:1]         mask_vec,
  output logic [N-1:1][PW-1:0] lvl_vec,
  output logic                 nest_en
);
  localparam int MB = PW;  // mask bit position inside a control register
  localparam logic [AW-1:0] A_MASK = AW'(0);
  localparam logic [AW-1:0] A_CFG  = AW'(1);

  logic [N-1:1]         mask_q;
  logic [N-1:1][PW-1:0] lvl_q;
  logic                 nest_q;

  // One storage bit per source, reachable from the global and the private view.
  for (genvar g = 1; g < N; g++) begin : g_src
    localparam logic [AW-1:0] A_CTL = AW'(CTL_BASE + g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[g] <= 1'b1;
        lvl_q[g]  <= '1;
      end else if (we && addr == A_MASK) begin
        mask_q[g] <= wdata[g];
      end else if (we && addr == A_CTL) begin
        mask_q[g] <= wdata[MB];
        lvl_q[g]  <= wdata[PW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   nest_q <= 1'b0;
    else if (we && addr == A_CFG) nest_q <= wdata[0];
  end

  always_comb begin
    rdata = '0;
    if (addr == A_MASK) rdata[N-1:1] = mask_q;
    if (addr == A_CFG)  rdata[0]     = nest_q;
    for (int i = 1; i < N; i++) begin
      if (addr == AW'(CTL_BASE + i)) begin
        rdata[MB]     = mask_q[i];
        rdata[PW-1:0] = lvl_q[i];
      end
    end
  end

  assign mask_vec = mask_q;
  assign lvl_vec  = lvl_q;
  assign nest_en  = nest_q;
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve #(
  parameter int N   = irq_pkg::SRC_DEF,
  parameter int PW  = irq_pkg::LVL_W_DEF,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]         req,
  input  logic [N-1:1]         mask_vec,
  input  logic [N-1:1][PW-1:0] lvl_vec,
  input  logic [N-1:0]         isr_vec,
  input  logic                 nest_en,
  output logic                 pick_valid,
  output logic [IDW-1:0]       pick_id,
  output logic                 nmi_go,
  output logic                 mask_go
);
  localparam int NONE_LVL = 1 << PW;  // worse than any real level

  int  best_lvl, best_idx, thr_lvl;
  logic found, any_isr;

  always_comb begin
    best_lvl = NONE_LVL;
    best_idx = 0;
    thr_lvl  = NONE_LVL;
    found    = 1'b0;
    any_isr  = 1'b0;
    for (int i = 1; i < N; i++) begin
      if (isr_vec[i]) begin
        any_isr = 1'b1;
        if (int'(lvl_vec[i]) < thr_lvl) thr_lvl = int'(lvl_vec[i]);
      end
      if (req[i] && !mask_vec[i] && !isr_vec[i] &&
          (!found || irq_pkg::outranks(int'(lvl_vec[i]), i, best_lvl, best_idx))) begin
        found    = 1'b1;
        best_lvl = int'(lvl_vec[i]);
        best_idx = i;
      end
    end
  end

  assign nmi_go  = req[0] && !isr_vec[0];
  assign mask_go = found && !isr_vec[0] &&
                   (nest_en ? (best_lvl < thr_lvl) : !any_isr);

  assign pick_valid = nmi_go || mask_go;
  assign pick_id    = nmi_go ? '0 : IDW'(best_idx);
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice #(
  parameter int N   = irq_pkg::SRC_DEF,
  parameter int IDW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ack_fire,
  input  logic [IDW-1:0] ack_id,
  input  logic           eoi,
  input  logic [IDW-1:0] eoi_id,
  output logic [N-1:0]   isr_vec
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                                isr_vec[g] <= 1'b0;
      else if (ack_fire && ack_id == IDW'(g))    isr_vec[g] <= 1'b1;  // set wins
      else if (eoi && eoi_id == IDW'(g))         isr_vec[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N        = irq_pkg::SRC_DEF,
  parameter int PW       = irq_pkg::LVL_W_DEF,
  parameter int AW       = irq_pkg::ADDR_W_DEF,
  parameter int CTL_BASE = irq_pkg::CTL_BASE_DEF,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32,
  localparam int IDW     = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     src_req,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [N-1:0]     reg_wdata,
  output logic [N-1:0]     reg_rdata,
  input  logic             irq_ack,
  input  logic             eoi,
  input  logic [IDW-1:0]   eoi_id,
  output logic             irq_valid,
  output logic [IDW-1:0]   irq_id,
  output logic [VEC_W-1:0] irq_vec
);
  logic [N-1:1]         mask_w;
  logic [N-1:1][PW-1:0] lvl_w;
  logic                 nest_w;
  logic [N-1:0]         isr_w;
  logic                 nmi_go_w, mask_go_w, ack_fire_w;

  irq_regs #(.N(N), .PW(PW), .AW(AW), .CTL_BASE(CTL_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .mask_vec(mask_w), .lvl_vec(lvl_w), .nest_en(nest_w)
  );

  irq_resolve #(.N(N), .PW(PW), .IDW(IDW)) u_res (
    .req(src_req), .mask_vec(mask_w), .lvl_vec(lvl_w), .isr_vec(isr_w),
    .nest_en(nest_w), .pick_valid(irq_valid), .pick_id(irq_id),
    .nmi_go(nmi_go_w), .mask_go(mask_go_w)
  );

  assign ack_fire_w = irq_ack && irq_valid;

  irq_inservice #(.N(N), .IDW(IDW)) u_isr (
    .clk(clk), .rst_n(rst_n), .ack_fire(ack_fire_w), .ack_id(irq_id),
    .eoi(eoi), .eoi_id(eoi_id), .isr_vec(isr_w)
  );

  assign irq_vec = VEC_W'(irq_pkg::vector_of(VEC_BASE, int'(irq_id)));
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N   = 12,
  parameter int IDW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   src_req,
  input logic           irq_ack,
  input logic           eoi,
  input logic [IDW-1:0] eoi_id,
  input logic           irq_valid,
  input logic [IDW-1:0] irq_id,
  input logic [N-1:1]   mask_vec,
  input logic [N-1:0]   isr_vec,
  input logic           nest_en,
  input logic           mask_go
);
  assert_masked_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_id != '0) |-> !mask_vec[irq_id]);

  assert_pick_requesting_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> src_req[irq_id]);

  assert_nmi_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req[0] && !isr_vec[0]) |-> (irq_valid && irq_id == '0));

  assert_nmi_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    isr_vec[0] |-> !mask_go);

  assert_ack_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack) |=> isr_vec[$past(irq_id)]);

  assert_eoi_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !(irq_valid && irq_ack && irq_id == eoi_id)) |=> !isr_vec[$past(eoi_id)]);

  assert_no_nest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_en && (|isr_vec[N-1:1]) && irq_valid) |-> irq_id == '0);

  assert_not_reentered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !isr_vec[irq_id]);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N(N), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .irq_ack(irq_ack), .eoi(eoi),
  .eoi_id(eoi_id), .irq_valid(irq_valid), .irq_id(irq_id), .mask_vec(mask_w),
  .isr_vec(isr_w), .nest_en(nest_w), .mask_go(mask_go_w)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] src_req = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic [11:0] reg_rdata;
  logic        irq_ack = 1'b0, eoi = 1'b0;
  logic [3:0]  eoi_id = '0;
  logic        irq_valid;
  logic [3:0]  irq_id;
  logic [7:0]  irq_vec;

  int total = 0, bad = 0;
  bit finished = 0;

  // Bench model of programmed state
  bit [11:0] m_mask;
  int        m_lvl [12];
  bit [11:0] m_isr;
  bit        m_nest;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack), .eoi(eoi),
    .eoi_id(eoi_id), .irq_valid(irq_valid), .irq_id(irq_id), .irq_vec(irq_vec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected pick: smallest key level*16+index among eligible sources.
  task automatic predict(output bit v, output int id);
    int best, thr;
    v = 0; id = 0;
    if (src_req[0] && !m_isr[0]) begin v = 1; return; end
    if (m_isr[0]) return;
    best = 1 << 10; thr = 8;
    for (int i = 1; i < 12; i++) begin
      if (m_isr[i] && m_lvl[i] < thr) thr = m_lvl[i];
      if (src_req[i] && !m_mask[i] && !m_isr[i] && (m_lvl[i] * 16 + i) < best)
        best = m_lvl[i] * 16 + i;
    end
    if (best < (1 << 10) && (m_nest ? (best / 16 < thr) : (m_isr[11:1] == 0))) begin
      v = 1; id = best % 16;
    end
  endtask

  task automatic compare(input string tag);
    bit v; int id;
    predict(v, id);
    chk({tag, " valid"}, int'(irq_valid), int'(v));
    if (v) begin
      chk({tag, " id"}, int'(irq_id), id);
      chk({tag, " vec R4"}, int'(irq_vec), 32 + id);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1; reg_addr = a[4:0]; reg_wdata = d[11:0];
    @(negedge clk);
    reg_we = 0;
    if (a == 0) m_mask = d[11:0] & 12'hFFE;
    else if (a == 1) m_nest = d[0];
    else if (a >= 17 && a <= 27) begin
      m_mask[a-16] = d[3];
      m_lvl[a-16]  = d & 7;
    end
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = a[4:0];
    #1 d = int'(reg_rdata);
  endtask

  task automatic step(input logic [11:0] r, input string tag);
    @(negedge clk);
    src_req = r;
    #1 compare(tag);
  endtask

  task automatic ack_with(input bit do_eoi, input int eid);
    bit v; int id;
    @(negedge clk);
    predict(v, id);
    irq_ack = 1; eoi = do_eoi; eoi_id = eid[3:0];
    @(negedge clk);
    irq_ack = 0; eoi = 0;
    if (do_eoi) m_isr[eid] = 0;
    if (v) m_isr[id] = 1;
  endtask

  task automatic eoi_only(input int eid);
    @(negedge clk);
    eoi = 1; eoi_id = eid[3:0];
    @(negedge clk);
    eoi = 0;
    m_isr[eid] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d;
    int pats [5] = '{12'h000, 12'hAAA, 12'h554, 12'hFFE, 12'h3C6};
    m_mask = 12'hFFE; m_nest = 0; m_isr = '0;
    for (int i = 0; i < 12; i++) m_lvl[i] = 7;
    src_req = 12'hFFE;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    #1 chk("R1 idle with maskable requests", int'(irq_valid), 0);
    rd(0, d);  chk("R1 mask reset", d, 12'hFFE);
    rd(19, d); chk("R1 ctl reset", d, 15);
    rd(1, d);  chk("R1 nest reset", d, 0);

    // R2 mirrored views
    foreach (pats[k]) begin
      wr(0, pats[k]);
      for (int i = 1; i < 12; i++) begin
        rd(16 + i, d);
        chk("R2 global->ctl mask", (d >> 3) & 1, (pats[k] >> i) & 1);
      end
      for (int i = 1; i < 12; i++) wr(16 + i, ((~(pats[k] >> i) & 1) << 3) | (i % 8));
      rd(0, d);
      chk("R2 ctl->global", d, ~pats[k] & 12'hFFE);
    end

    // R9 nest readback
    wr(1, 1); rd(1, d); chk("R9 nest set", d, 1);
    wr(1, 0); rd(1, d); chk("R9 nest clear", d, 0);

    // R10 unused addresses
    wr(0, 12'h0F0);
    wr(2, 12'hFFF); wr(31, 12'hFFF); wr(16, 12'hFFF);
    rd(2, d);  chk("R10 unused read 2", d, 0);
    rd(31, d); chk("R10 unused read 31", d, 0);
    rd(16, d); chk("R10 unused read 16", d, 0);
    rd(0, d);  chk("R10 mask untouched", d, 12'h0F0);
    rd(1, d);  chk("R10 cfg untouched", d, 0);

    // R4 / R3 sweep with tied levels
    for (int i = 1; i < 12; i++) wr(16 + i, (i * 3) % 8);
    foreach (pats[k]) begin
      wr(0, pats[k]);
      for (int r = 0; r < 2048; r++) step({r[10:0], 1'b0}, "R4 sweep");
    end

    // R3 mask write takes effect at once
    wr(0, 0);
    step(12'hFFE, "R3 before write");
    wr(0, 12'h100);
    #1 compare("R3 right after write");
    chk("R3 masked 8 not chosen", int'(irq_id), 3);

    // R5 non-maskable
    wr(0, 12'hFFE);
    step(12'hFFF, "R5 nmi with all masked");
    wr(0, 0);
    step(12'hFFF, "R5 nmi over maskable");
    ack_with(0, 0);
    step(12'hFFF, "R5 nmi in service blocks");
    step(12'h002, "R5 nmi in service blocks single");
    eoi_only(0);
    step(12'h002, "R5 after nmi eoi");

    // R6 / R7 without nesting
    step(12'h020, "R6 present 5");
    ack_with(0, 0);
    step(12'h120, "R7 blocked while 5 in service");
    step(12'hFFE, "R7 blocked all");
    eoi_only(5);
    step(12'h120, "R6 after eoi 8 shows");

    // R8 nesting
    wr(1, 1);
    step(12'h020, "R8 present 5");
    ack_with(0, 0);
    step(12'h122, "R8 higher preempts");
    ack_with(0, 0);
    step(12'h12A, "R8 nothing beats level 0");
    eoi_only(8);
    step(12'h12A, "R8 after eoi 8");
    step(12'h040, "R8 level 2 beats 7");
    step(12'h800, "R8 level 1 beats 7");

    // R6 collision: ack 3 while eoi closes 5
    step(12'h028, "R6 present 3 nested");
    ack_with(1, 5);
    step(12'h020, "R6 collision 5 reopened");
    step(12'h100, "R6 collision 3 held");
    eoi_only(3);
    step(12'h020, "R6 after eoi 3");

    // R6 collision same index, nest off: mark stays set
    wr(1, 0);
    step(12'h004, "R6 present 2");
    ack_with(1, 2);
    step(12'h104, "R6 same-index set wins");
    eoi_only(2);
    step(12'h104, "R6 released");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule